// File: doc/BRIEF.md
# Dual-Channel Compare-Match PWM Generator

This block is a free-running up-counter that produces two pulse-width-modulated outputs, channel 0 and channel 1, from one shared period and one duty value per channel. Each cycle of the counter starts with both enabled outputs high. An output falls when the counter reaches that channel's compare value and rises again at the start of the next cycle. A one-clock overflow strobe marks the last count of every cycle. Each channel has its own enable, its own idle level and its own polarity inversion. The counter width is the parameter `CNT_W`; 16-bit and 32-bit builds are the intended ones.

Software-side logic drives the block through a single-cycle register-write port. The port carries a command word (start, stop, clear counter, clear error), the period, a per-channel duty value and a per-channel pin configuration. While the timer runs, period and duty writes land in buffer registers and reach the active registers only when the counter wraps, so a waveform never shows a half-updated cycle. While the timer is halted, the active registers follow the buffers directly, so the first cycle after a start already uses the newest values.

The timebase is a three-state machine. ST_HALT holds the counter frozen and drives every output to its idle level. Transition START (a start command without a stop command) leads from ST_HALT to ST_FIRST. In ST_FIRST a channel whose idle level is low stays low until the first wrap, and a channel whose idle level is high follows the normal waveform. Transition WRAP leads from ST_FIRST to ST_STEADY, where both channels follow the normal waveform. Transition STOP leads from ST_FIRST or ST_STEADY back to ST_HALT. A start command in a running state is ignored. The clear command acts in every state and does not change the state.

Top module: `dual_pwm_gen`

## Requirements
- R1: While running, the counter steps 0, 1, ..., P-1 and then wraps to 0, where P is the active period. `ovf_o` is high exactly during the clock in which the count equals P-1, so it is high once every P clocks, and it is never high while halted.
- R2: The compare value C sets the waveform. With polarity not inverted, C equals the duty value D. In steady running, an enabled output is high while the count is below C and low from the count C to the end of the cycle. So D = 0 gives an output low for the whole cycle, and D >= P gives an output high for the whole cycle.
- R3: With inversion selected (pin-config bit 2 = 1), the compare value is P-D, or 0 when D >= P. The output is then low for D clocks of each cycle, or for the whole cycle when D >= P.
- R4: A period or duty write made while running leaves the current cycle unchanged and takes effect from the next wrap. A write made while halted takes effect at once.
- R5: The idle level is pin-config bit 1. While halted, every output equals its idle level. After a start, an output whose idle level is 0 stays low until the first wrap. An output whose idle level is 1 follows R2/R3 from the start.
- R6: The enable is pin-config bit 0. An output whose enable is 0 always equals its idle level.
- R7: The command word is written at address 0. Bit 0 is start and bit 1 is stop; stop wins when both are set. A stop freezes the counter, and a later start resumes counting from the frozen value.
- R8: Command bit 2 clears the counter to 0 on the next clock, in any state. In the same clock it takes priority over counting.
- R9: Writes to address 1 set the period. Their legal range is 1 to 2^CNT_W-1 (65535 in the 16-bit build). A write of 0 or above that range is dropped and sets `err_o`.
- R10: Writes to address 2 set the duty value and writes to address 3 set the pin config, each for the channel given on `wr_chan`. Only channel 0 and channel 1 are valid. A duty or config write to channel 2 or 3 is dropped and sets `err_o`. Command bit 3 clears `err_o`.
- R11: After reset, the block is halted with the counter at 0. The period is 2^CNT_W-1, the duty values are 0, and every pin config is 0. Both outputs, `ovf_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_addr | input | 2 | 0 command, 1 period, 2 duty, 3 pin config |
| wr_chan | input | 2 | Channel index for duty and pin-config writes |
| wr_data | input | 32 | Write data |
| pwm_o | output | 2 | PWM outputs, bit 0 = channel 0, bit 1 = channel 1 |
| ovf_o | output | 1 | High during the last count of each cycle |
| err_o | output | 1 | Sticky flag for rejected writes |

## Verification
The bench sweeps small periods from 1 to 7 against every duty value from 0 to P+1, in both polarities. In each run it counts high clocks and overflow positions over a full cycle. This separates the inclusive and exclusive compare edges, the saturation at D >= P and the inverted subtraction. Mid-cycle writes while running, sampled before and after the wrap, tell buffered loading apart from immediate loading. Halt/start sequences with a low and a high idle level separate the first-cycle behaviour from steady running. Stop, clear and restart sequences reveal where the frozen or cleared count resumes. Out-of-range periods whose low bits look legal, and writes to channels 2 and 3, show whether a rejected write leaves the waveform unchanged.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    localparam int BUS_W    = 32;
    localparam int NUM_PINS = 2;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_PERIOD = 2'd1;
    localparam logic [1:0] ADDR_DUTY   = 2'd2;
    localparam logic [1:0] ADDR_PINCFG = 2'd3;

    // command word bits
    localparam int CMD_START   = 0;
    localparam int CMD_STOP    = 1;
    localparam int CMD_CLR_CNT = 2;
    localparam int CMD_CLR_ERR = 3;

    typedef enum logic [1:0] {
        ST_HALT   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_STEADY = 2'd2
    } tb_state_e;

    typedef struct packed {
        logic inv;
        logic idle;
        logic en;
    } pin_cfg_t;

endpackage

// File: rtl/dpwm_regs.sv
module dpwm_regs
    import dpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [1:0]                         wr_addr,
    input  logic [1:0]                         wr_chan,
    input  logic [BUS_W-1:0]                   wr_data,
    output logic                               start_cmd,
    output logic                               stop_cmd,
    output logic                               clr_cnt,
    output logic                               per_reject,
    output logic [CNT_W-1:0]                   per_buf,
    output logic [NUM_PINS-1:0][CNT_W-1:0]     duty_buf,
    output pin_cfg_t [NUM_PINS-1:0]            cfg,
    output logic                               err_o
);

    localparam logic [63:0] PER_MAX = (64'd1 << CNT_W) - 64'd1;

    logic [63:0]       data_wide;
    logic              is_ctrl, is_per, is_duty, is_cfg;
    logic              chan_ok, chan_reject, clr_err;
    logic [CNT_W-1:0]  duty_sat;

    assign data_wide = {{(64-BUS_W){1'b0}}, wr_data};
    assign is_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
    assign is_per    = wr_en && (wr_addr == ADDR_PERIOD);
    assign is_duty   = wr_en && (wr_addr == ADDR_DUTY);
    assign is_cfg    = wr_en && (wr_addr == ADDR_PINCFG);

    assign start_cmd = is_ctrl && wr_data[CMD_START];
    assign stop_cmd  = is_ctrl && wr_data[CMD_STOP];
    assign clr_cnt   = is_ctrl && wr_data[CMD_CLR_CNT];
    assign clr_err   = is_ctrl && wr_data[CMD_CLR_ERR];

    assign chan_ok     = (wr_chan < 2'(NUM_PINS));
    assign chan_reject = (is_duty || is_cfg) && !chan_ok;
    assign per_reject  = is_per && ((wr_data == '0) || (data_wide > PER_MAX));

    // duty values beyond the counter range saturate (always >= any period)
    assign duty_sat = (data_wide > PER_MAX) ? '1 : wr_data[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_buf <= '1;
        end else if (is_per && !per_reject) begin
            per_buf <= wr_data[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_o <= 1'b0;
        end else if (per_reject || chan_reject) begin
            err_o <= 1'b1;
        end else if (clr_err) begin
            err_o <= 1'b0;
        end
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin_regs
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                duty_buf[g] <= '0;
                cfg[g]      <= '0;
            end else begin
                if (is_duty && (wr_chan == 2'(g))) begin
                    duty_buf[g] <= duty_sat;
                end
                if (is_cfg && (wr_chan == 2'(g))) begin
                    cfg[g] <= wr_data[2:0];
                end
            end
        end
    end

endmodule

// File: rtl/dpwm_timebase.sv
module dpwm_timebase
    import dpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_cmd,
    input  logic             stop_cmd,
    input  logic             clr_cnt,
    input  logic [CNT_W-1:0] per_buf,
    output tb_state_e        st_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] per_act,
    output logic             wrap,
    output logic             load_act
);

    tb_state_e st_d;
    logic      running;
    logic      at_end;

    assign running  = (st_q != ST_HALT);
    assign at_end   = (cnt_q >= (per_act - 1'b1));
    assign wrap     = running && at_end;
    assign load_act = (st_q == ST_HALT) || wrap;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_HALT;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HALT: begin
                if (start_cmd && !stop_cmd) st_d = ST_FIRST;
            end
            ST_FIRST: begin
                if (stop_cmd)  st_d = ST_HALT;
                else if (wrap) st_d = ST_STEADY;
            end
            ST_STEADY: begin
                if (stop_cmd) st_d = ST_HALT;
            end
            default: st_d = ST_HALT;
        endcase
    end

    // counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_cnt) begin
            cnt_q <= '0;
        end else if (running) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end

    // active period: follows the buffer while halted, else loads at wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_act <= '1;
        end else if (load_act) begin
            per_act <= per_buf;
        end
    end

endmodule

// File: rtl/dpwm_pin.sv
module dpwm_pin
    import dpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_act,
    input  logic [CNT_W-1:0] duty_buf,
    input  logic [CNT_W-1:0] per_act,
    input  logic [CNT_W-1:0] cnt_q,
    input  pin_cfg_t         cfg,
    input  tb_state_e        st_q,
    output logic             pwm
);

    logic [CNT_W-1:0] duty_act;
    logic [CNT_W-1:0] cmp;
    logic             below;
    logic             level;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_act <= '0;
        end else if (load_act) begin
            duty_act <= duty_buf;
        end
    end

    always_comb begin
        if (cfg.inv) begin
            cmp = (duty_act >= per_act) ? '0 : (per_act - duty_act);
        end else begin
            cmp = duty_act;
        end
    end

    assign below = (cnt_q < cmp);

    // output level per timebase state
    always_comb begin
        level = cfg.idle;
        unique case (st_q)
            ST_HALT:   level = cfg.idle;
            ST_FIRST:  level = cfg.idle & below;
            ST_STEADY: level = below;
            default:   level = cfg.idle;
        endcase
    end

    assign pwm = cfg.en ? level : cfg.idle;

endmodule

// File: rtl/dual_pwm_gen.sv
module dual_pwm_gen
    import dpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [1:0]  wr_chan,
    input  logic [31:0] wr_data,
    output logic [1:0]  pwm_o,
    output logic        ovf_o,
    output logic        err_o
);

    logic                           start_cmd, stop_cmd, clr_cnt, per_reject;
    logic [CNT_W-1:0]               per_buf, per_act, cnt_q;
    logic [NUM_PINS-1:0][CNT_W-1:0] duty_buf;
    pin_cfg_t [NUM_PINS-1:0]        cfg;
    tb_state_e                      st_q;
    logic                           wrap, load_act;
    logic [NUM_PINS-1:0]            en_vec, idle_vec;

    dpwm_regs #(.CNT_W(CNT_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_chan    (wr_chan),
        .wr_data    (wr_data),
        .start_cmd  (start_cmd),
        .stop_cmd   (stop_cmd),
        .clr_cnt    (clr_cnt),
        .per_reject (per_reject),
        .per_buf    (per_buf),
        .duty_buf   (duty_buf),
        .cfg        (cfg),
        .err_o      (err_o)
    );

    dpwm_timebase #(.CNT_W(CNT_W)) tbase_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_cmd (start_cmd),
        .stop_cmd  (stop_cmd),
        .clr_cnt   (clr_cnt),
        .per_buf   (per_buf),
        .st_q      (st_q),
        .cnt_q     (cnt_q),
        .per_act   (per_act),
        .wrap      (wrap),
        .load_act  (load_act)
    );

    assign ovf_o = wrap;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        dpwm_pin #(.CNT_W(CNT_W)) pin_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_act (load_act),
            .duty_buf (duty_buf[g]),
            .per_act  (per_act),
            .cnt_q    (cnt_q),
            .cfg      (cfg[g]),
            .st_q     (st_q),
            .pwm      (pwm_o[g])
        );
        assign en_vec[g]   = cfg[g].en;
        assign idle_vec[g] = cfg[g].idle;
    end

endmodule

// File: rtl/dual_pwm_gen_chk.sv
module dual_pwm_gen_chk
    import dpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input tb_state_e        st_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] per_act,
    input logic             clr_cnt,
    input logic             per_reject,
    input logic [1:0]       pwm_o,
    input logic             ovf_o,
    input logic             err_o,
    input logic [1:0]       en_vec,
    input logic [1:0]       idle_vec
);

    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (cnt_q == '0));

    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_HALT && !ovf_o && !clr_cnt) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    a_r1_no_ovf_halted: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALT) |-> !ovf_o);

    a_r4_period_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_HALT && !ovf_o) |=> $stable(per_act));

    a_r5_halt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALT) |-> (pwm_o == idle_vec));

    a_r6_disabled_a: assert property (@(posedge clk) disable iff (!rst_n)
        !en_vec[0] |-> (pwm_o[0] == idle_vec[0]));

    a_r6_disabled_b: assert property (@(posedge clk) disable iff (!rst_n)
        !en_vec[1] |-> (pwm_o[1] == idle_vec[1]));

    a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALT && !clr_cnt) |=> $stable(cnt_q));

    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cnt |=> (cnt_q == '0));

    a_r9_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
        per_reject |=> err_o);

endmodule

bind dual_pwm_gen dual_pwm_gen_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_q       (st_q),
    .cnt_q      (cnt_q),
    .per_act    (per_act),
    .clr_cnt    (clr_cnt),
    .per_reject (per_reject),
    .pwm_o      (pwm_o),
    .ovf_o      (ovf_o),
    .err_o      (err_o),
    .en_vec     (en_vec),
    .idle_vec   (idle_vec)
);

// File: tb/dual_pwm_gen_tb_top.sv
`timescale 1ns/1ps
module dual_pwm_gen_tb_top;

    localparam int CNT_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [1:0]  wr_chan = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  pwm_o;
    logic        ovf_o;
    logic        err_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dual_pwm_gen #(.CNT_W(CNT_W)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_chan (wr_chan),
        .wr_data (wr_data),
        .pwm_o   (pwm_o),
        .ovf_o   (ovf_o),
        .err_o   (err_o)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // called at a negedge, returns at the next negedge
    task automatic wr(input logic [1:0] a, input logic [1:0] c, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_chan = c; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // samples n clocks starting at the current negedge
    task automatic measure(input int n, output int hia, output int hib,
                           output int novf, output int first_ovf);
        hia = 0; hib = 0; novf = 0; first_ovf = -1;
        for (int k = 0; k < n; k++) begin
            if (pwm_o[0]) hia++;
            if (pwm_o[1]) hib++;
            if (ovf_o) begin
                novf++;
                if (first_ovf < 0) first_ovf = k;
            end
            @(negedge clk);
        end
    endtask

    function automatic int exp_high(input int p, input int d, input bit inv);
        if (inv) return (d >= p) ? 0 : p - d;
        return (d >= p) ? p : d;
    endfunction

    // command word: bit0 start, bit1 stop, bit2 clear count, bit3 clear error
    // pin config: bit0 enable, bit1 idle level, bit2 invert
    initial begin
        int ha, hb, no, fo;
        int plist [5] = '{1, 2, 3, 4, 7};
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk(pwm_o == 2'b00, "R11 outputs after reset", pwm_o, 0);
        chk(ovf_o == 1'b0, "R11 ovf after reset", ovf_o, 0);
        chk(err_o == 1'b0, "R11 err after reset", err_o, 0);
        measure(4, ha, hb, no, fo);
        chk(no == 0, "R11 halted after reset, no ovf", no, 0);

        // R1 R2 R3 sweep
        foreach (plist[pi]) begin
            for (int inv = 0; inv < 2; inv++) begin
                for (int d = 0; d <= plist[pi] + 1; d++) begin
                    int p = plist[pi];
                    int db = (d + 1) % (p + 2);
                    wr(2'd0, 2'd0, 32'h2);
                    wr(2'd0, 2'd0, 32'h4);
                    wr(2'd1, 2'd0, 32'(p));
                    wr(2'd2, 2'd0, 32'(d));
                    wr(2'd2, 2'd1, 32'(db));
                    wr(2'd3, 2'd0, 32'(1 | (inv << 2)));
                    wr(2'd3, 2'd1, 32'(3 | (inv << 2)));
                    wr(2'd0, 2'd0, 32'h1);
                    wait_n(p);
                    measure(p, ha, hb, no, fo);
                    chk(ha == exp_high(p, d, inv[0]),
                        $sformatf("R2/R3 ch0 high count P=%0d D=%0d inv=%0d", p, d, inv), ha, exp_high(p, d, inv[0]));
                    chk(hb == exp_high(p, db, inv[0]),
                        $sformatf("R2/R3 ch1 high count P=%0d D=%0d inv=%0d", p, db, inv), hb, exp_high(p, db, inv[0]));
                    chk(no == 1, $sformatf("R1 ovf count P=%0d", p), no, 1);
                    chk(fo == p - 1, $sformatf("R1 ovf position P=%0d", p), fo, p - 1);
                end
            end
        end

        // R4 buffered update while running
        wr(2'd0, 2'd0, 32'h2);
        wr(2'd0, 2'd0, 32'h4);
        wr(2'd1, 2'd0, 32'd4);
        wr(2'd2, 2'd0, 32'd1);
        wr(2'd3, 2'd0, 32'h1);
        wr(2'd3, 2'd1, 32'h0);
        wr(2'd0, 2'd0, 32'h1);
        wait_n(4);                 // count 0, steady
        wr(2'd1, 2'd0, 32'd6);     // count 1
        wr(2'd2, 2'd0, 32'd3);     // count 2
        chk(pwm_o[0] == 1'b0, "R4 old duty kept in current cycle", pwm_o[0], 0);
        @(negedge clk);            // count 3
        chk(ovf_o == 1'b1, "R4 old period kept in current cycle", ovf_o, 1);
        @(negedge clk);            // count 0 with new values
        measure(6, ha, hb, no, fo);
        chk(ha == 3, "R4 new duty after wrap", ha, 3);
        chk(fo == 5, "R4 new period after wrap", fo, 5);

        // R5 idle level and first cycle
        wr(2'd0, 2'd0, 32'h2);
        wr(2'd0, 2'd0, 32'h4);
        wr(2'd1, 2'd0, 32'd4);
        wr(2'd2, 2'd0, 32'd2);
        wr(2'd2, 2'd1, 32'd2);
        wr(2'd3, 2'd0, 32'h1);     // enabled, idle low
        wr(2'd3, 2'd1, 32'h3);     // enabled, idle high
        chk(pwm_o == 2'b10, "R5 halted outputs at idle", pwm_o, 2);
        wr(2'd0, 2'd0, 32'h1);
        measure(4, ha, hb, no, fo);
        chk(ha == 0, "R5 idle-low channel low until first wrap", ha, 0);
        chk(hb == 2, "R5 idle-high channel normal in first cycle", hb, 2);
        measure(4, ha, hb, no, fo);
        chk(ha == 2, "R5 idle-low channel normal after wrap", ha, 2);
        wr(2'd0, 2'd0, 32'h2);
        chk(pwm_o == 2'b10, "R5 stop returns outputs to idle", pwm_o, 2);
        wr(2'd3, 2'd0, 32'h3);
        chk(pwm_o[0] == 1'b1, "R5 new idle level while halted", pwm_o[0], 1);

        // R7 freeze and resume, stop wins over start
        wr(2'd0, 2'd0, 32'h4);
        wr(2'd0, 2'd0, 32'h1);     // count 0 running
        @(negedge clk);            // count 1
        wr(2'd0, 2'd0, 32'h2);     // stop edge counts to 2
        wr(2'd0, 2'd0, 32'h3);     // start+stop: stays halted
        measure(5, ha, hb, no, fo);
        chk(no == 0, "R7 stop wins over start", no, 0);
        wr(2'd0, 2'd0, 32'h1);     // resume at 2
        chk(ovf_o == 1'b0, "R7 resume from frozen count (2)", ovf_o, 0);
        @(negedge clk);
        chk(ovf_o == 1'b1, "R7 resume from frozen count (3)", ovf_o, 1);

        // R8 clear while running
        wait_n(2);                 // count 1
        wr(2'd0, 2'd0, 32'h4);     // count 0
        measure(4, ha, hb, no, fo);
        chk(fo == 3, "R8 clear restarts count at 0", fo, 3);

        // R6 disabled outputs
        wr(2'd0, 2'd0, 32'h2);
        wr(2'd0, 2'd0, 32'h4);
        wr(2'd3, 2'd0, 32'h2);     // disabled, idle high
        wr(2'd3, 2'd1, 32'h0);     // disabled, idle low
        wr(2'd0, 2'd0, 32'h1);
        wait_n(4);
        measure(4, ha, hb, no, fo);
        chk(ha == 4, "R6 disabled ch0 held at idle high", ha, 4);
        chk(hb == 0, "R6 disabled ch1 held at idle low", hb, 0);

        // R9 period range
        wr(2'd0, 2'd0, 32'h2);
        wr(2'd0, 2'd0, 32'h4);
        wr(2'd1, 2'd0, 32'd0);
        chk(err_o == 1'b1, "R9 period 0 rejected", err_o, 1);
        wr(2'd0, 2'd0, 32'h8);
        chk(err_o == 1'b0, "R10 error clear command", err_o, 0);
        wr(2'd1, 2'd0, 32'd261);
        chk(err_o == 1'b1, "R9 period above range rejected", err_o, 1);
        wr(2'd3, 2'd0, 32'h1);
        wr(2'd2, 2'd0, 32'd2);
        // R10 invalid channels
        wr(2'd0, 2'd0, 32'h8);
        wr(2'd2, 2'd2, 32'd0);
        chk(err_o == 1'b1, "R10 duty write to channel 2 rejected", err_o, 1);
        wr(2'd0, 2'd0, 32'h8);
        wr(2'd3, 2'd3, 32'h0);
        chk(err_o == 1'b1, "R10 config write to channel 3 rejected", err_o, 1);
        wr(2'd0, 2'd0, 32'h1);
        wait_n(4);
        measure(4, ha, hb, no, fo);
        chk(fo == 3, "R9 period unchanged after rejected writes", fo, 3);
        chk(ha == 2, "R10 ch0 duty and config unchanged", ha, 2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired (all R) actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule